// File: doc/BRIEF.md
# Real-Time Clock Counter Core with Alarms

This block keeps time for a chip from a single-cycle 256 Hz tick. An 8-bit fraction-of-second counter advances on every tick. A 32-bit seconds counter advances each time the fraction wraps from 0xFF to 0x00. Software reaches the counters, two alarms and a control/status word through a small synchronous register bus. Writes take effect on the clock edge, and reads are combinational from the address.

Two alarms feed one interrupt line, together with a ready indication.
- The time-of-day alarm watches the low 20 bits of the seconds counter.
- The periodic alarm reloads a down-counter from a 32-bit value and fires once per period.

Changes to the run enable and to the two alarm interrupt enables pass through a fixed busy window. This window stands in for a clock-domain crossing: the new values apply only when the window closes. Changing the run enable also needs an unlock bit that was set beforehand.

Top module: `rtc_core`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While running, a tick seen on one clock edge advances the fraction counter by one on the next edge. When the fraction counter moves from 0xFF to 0x00, the seconds counter gains one on that same edge.
- R3: While the run enable is 0, ticks leave both counters unchanged.
- R4: The register offsets are seconds 0x00, fraction 0x04, time-of-day alarm 0x08 (20 bits), periodic reload 0x0C and control 0x10. The first four read back what was written.
- R5: A new value for the run enable (control bit 0) is taken only if the unlock bit (control bit 15) already reads 1 and busy is 0. Otherwise the run enable keeps its value.
- R6: A control write made while busy (bit 3) is 0 raises busy for exactly 4 clock cycles. Bits 0, 1 and 2 keep reading their old values until busy falls, and then read the new values. Values written to bits 0 to 2 while busy is 1 are discarded.
- R7: Ready (bit 4) is cleared on the edge where a running tick is seen and set on the following update edge. Writing 0 to bit 4 clears it. Writing 1 to bit 4 does not set it.
- R8: When counting makes the low 20 bits of the seconds counter equal the time-of-day alarm value, flag bit 6 is set one edge after that update. Writing 0 to bit 6 clears the flag.
- R9: While its interrupt enable (bit 2) is 0, the periodic counter holds the reload value. Once bit 2 is enabled, the flag (bit 7) is set on every max(reload,1)-th count update, and the counter reloads at that moment.
- R10: `irq` is high exactly when at least one of these holds: flag 6 with enable 1, flag 7 with enable 2, or ready with ready enable (bit 5).
- R11: Writing 1 to bit 6 or bit 7 never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle 256 Hz count pulse |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Combined interrupt and wake request |

## Verification
The assertions assume three things about the inputs:
- `tick` is a one-cycle pulse with at least one idle cycle after it, so a count update never overlaps the next tick.
- The bus makes at most one access per cycle.
- `BUSY_CYC` is at least 1.

The stimulus raises `tick` for a single cycle and always leaves an idle cycle after the update. It issues each bus access on its own clock edge. It uses the default busy length, so the busy window and the enable hand-over are checked at fixed cycle offsets.

// File: rtl/rtc_core_pkg.sv
// Package: register offsets and control-word bit positions shared by the
// RTC core and its bench. Assumes byte addressing with 32-bit registers.
package rtc_core_pkg;
    localparam int OFS_SECONDS = 'h00;
    localparam int OFS_FRACT   = 'h04;
    localparam int OFS_TODALM  = 'h08;
    localparam int OFS_PERLOAD = 'h0C;
    localparam int OFS_CONTROL = 'h10;

    localparam int CB_RUN    = 0;
    localparam int CB_TODIE  = 1;
    localparam int CB_PERIE  = 2;
    localparam int CB_BUSY   = 3;
    localparam int CB_RDY    = 4;
    localparam int CB_RDYIE  = 5;
    localparam int CB_TODF   = 6;
    localparam int CB_PERF   = 7;
    localparam int CB_UNLOCK = 15;
endpackage

// File: rtl/rtc_ctl.sv
// Module: control/status word of the RTC. It holds the unlock bit, the
// busy window that delays the run and alarm enables, the ready flag, both
// alarm flags and the interrupt combine. Assumes tick is a one-cycle pulse
// and that BUSY_CYC >= 1.
module rtc_ctl
    import rtc_core_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tod_hit,
    input  logic              per_hit,
    output logic              run,
    output logic              tod_ie,
    output logic              per_ie,
    output logic              step,
    output logic [DATA_W-1:0] ctl_rd,
    output logic              irq
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] busy_cnt;
    logic          busy;
    logic          pend_run, pend_tod, pend_per;
    logic          unlock, rdy_ie, rdy, tod_f, per_f;

    assign busy = (busy_cnt != '0);

    // Busy window: capture pending enables and apply them when it closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            pend_run <= 1'b0;
            pend_tod <= 1'b0;
            pend_per <= 1'b0;
            run      <= 1'b0;
            tod_ie   <= 1'b0;
            per_ie   <= 1'b0;
        end else if (ctl_wr && !busy) begin
            busy_cnt <= BW'(BUSY_CYC);
            pend_tod <= wdata[CB_TODIE];
            pend_per <= wdata[CB_PERIE];
            if (unlock) pend_run <= wdata[CB_RUN];
        end else if (busy) begin
            busy_cnt <= busy_cnt - 1'b1;
            if (busy_cnt == BW'(1)) begin
                run    <= pend_run;
                tod_ie <= pend_tod;
                per_ie <= pend_per;
            end
        end
    end

    // Unlock and ready-enable bits: written directly on any control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlock <= 1'b0;
            rdy_ie <= 1'b0;
        end else if (ctl_wr) begin
            unlock <= wdata[CB_UNLOCK];
            rdy_ie <= wdata[CB_RDYIE];
        end
    end

    // Count strobe: one cycle after a tick taken while running.
    always_ff @(posedge clk) begin
        if (!rst_n) step <= 1'b0;
        else        step <= tick && run;
    end

    // Ready flag: cleared on the tick, set on the update, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rdy <= 1'b0;
        else if (step)                     rdy <= 1'b1;
        else if (tick && run)              rdy <= 1'b0;
        else if (ctl_wr && !wdata[CB_RDY]) rdy <= 1'b0;
    end

    // Alarm flags: hardware set wins, writing 0 clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_f <= 1'b0;
            per_f <= 1'b0;
        end else begin
            if (tod_hit)                        tod_f <= 1'b1;
            else if (ctl_wr && !wdata[CB_TODF]) tod_f <= 1'b0;
            if (per_hit)                        per_f <= 1'b1;
            else if (ctl_wr && !wdata[CB_PERF]) per_f <= 1'b0;
        end
    end

    // Read view of the control word.
    always_comb begin
        ctl_rd            = '0;
        ctl_rd[CB_RUN]    = run;
        ctl_rd[CB_TODIE]  = tod_ie;
        ctl_rd[CB_PERIE]  = per_ie;
        ctl_rd[CB_BUSY]   = busy;
        ctl_rd[CB_RDY]    = rdy;
        ctl_rd[CB_RDYIE]  = rdy_ie;
        ctl_rd[CB_TODF]   = tod_f;
        ctl_rd[CB_PERF]   = per_f;
        ctl_rd[CB_UNLOCK] = unlock;
    end

    assign irq = (tod_f && tod_ie) || (per_f && per_ie) || (rdy && rdy_ie);

    assert_run_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run) |-> ($past(busy_cnt) == BW'(1)));
    assert_run_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !unlock) |=> (pend_run == $past(pend_run)));
    assert_rdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> rdy);
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tod_hit && !ctl_wr) |=> $stable(tod_f));
endmodule

// File: rtl/rtc_count.sv
// Module: fraction-of-second and seconds counters. Advance on the count
// strobe; a bus write to either counter takes priority over counting.
// Assumes the strobe is a one-cycle pulse.
module rtc_count #(
    parameter int DATA_W = 32,
    parameter int SUB_W  = 8,
    parameter int SEC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_sub,
    input  logic              wr_sec,
    input  logic [DATA_W-1:0] wdata,
    output logic [SUB_W-1:0]  sub,
    output logic [SEC_W-1:0]  sec,
    output logic              sec_step
);
    localparam logic [SUB_W-1:0] SUB_MAX = '1;

    logic wrap;
    assign wrap = step && (sub == SUB_MAX);

    // Fraction counter: load on write, else advance on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      sub <= '0;
        else if (wr_sub) sub <= wdata[SUB_W-1:0];
        else if (step)   sub <= sub + 1'b1;
    end

    // Seconds counter: load on write, else advance on fraction wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      sec <= '0;
        else if (wr_sec) sec <= wdata[SEC_W-1:0];
        else if (wrap)   sec <= sec + 1'b1;
    end

    // Marks the cycle in which the seconds value was just advanced by counting.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_step <= 1'b0;
        else        sec_step <= wrap && !wr_sec;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_sub && !wr_sec) |=> (sub == '0 && sec == $past(sec) + SEC_W'(1)));
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_sub && !wr_sec) |=> ($stable(sub) && $stable(sec)));
endmodule

// File: rtl/rtc_per_alarm.sv
// Module: periodic alarm down-counter. It holds the reload value while
// inactive. When active it counts down on each strobe and pulses hit when
// it reloads. A reload of 0 behaves as 1.
module rtc_per_alarm #(
    parameter int ALM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             step,
    input  logic [ALM_W-1:0] reload,
    output logic             hit
);
    logic [ALM_W-1:0] cnt;
    logic             last;

    assign last = (cnt <= ALM_W'(1));
    assign hit  = active && step && last;

    // Down-counter with reload at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= reload;
        else if (step)    cnt <= last ? reload : cnt - 1'b1;
    end

    assert_idle_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == $past(reload)));
    assert_count_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !last) |=> (cnt == $past(cnt) - ALM_W'(1)));
endmodule

// File: rtl/rtc_core.sv
// Module: top of the RTC core. It decodes the register bus, keeps the
// time-of-day and reload registers, compares the time of day and ties the
// counter, periodic alarm and control word together. Assumes one bus
// access per cycle; reads are combinational.
module rtc_core
    import rtc_core_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int SUB_W    = 8,
    parameter int SEC_W    = 32,
    parameter int TOD_W    = 20,
    parameter int ALM_W    = 32,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              wr_any, wr_sec, wr_sub, wr_tod, wr_load, wr_ctl;
    logic [SUB_W-1:0]  sub;
    logic [SEC_W-1:0]  sec;
    logic              sec_step, step, run, tod_ie, per_ie;
    logic              tod_hit, per_hit;
    logic [TOD_W-1:0]  tod_val;
    logic [ALM_W-1:0]  load_val;
    logic [DATA_W-1:0] ctl_rd;

    assign wr_any  = bus_sel && bus_wr;
    assign wr_sec  = wr_any && (bus_addr == ADDR_W'(OFS_SECONDS));
    assign wr_sub  = wr_any && (bus_addr == ADDR_W'(OFS_FRACT));
    assign wr_tod  = wr_any && (bus_addr == ADDR_W'(OFS_TODALM));
    assign wr_load = wr_any && (bus_addr == ADDR_W'(OFS_PERLOAD));
    assign wr_ctl  = wr_any && (bus_addr == ADDR_W'(OFS_CONTROL));

    // Alarm value registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_val  <= '0;
            load_val <= '0;
        end else begin
            if (wr_tod)  tod_val  <= bus_wdata[TOD_W-1:0];
            if (wr_load) load_val <= bus_wdata[ALM_W-1:0];
        end
    end

    assign tod_hit = sec_step && (sec[TOD_W-1:0] == tod_val);

    rtc_count #(.DATA_W(DATA_W), .SUB_W(SUB_W), .SEC_W(SEC_W)) u_count (
        .clk(clk), .rst_n(rst_n), .step(step), .wr_sub(wr_sub), .wr_sec(wr_sec),
        .wdata(bus_wdata), .sub(sub), .sec(sec), .sec_step(sec_step)
    );

    rtc_per_alarm #(.ALM_W(ALM_W)) u_per (
        .clk(clk), .rst_n(rst_n), .active(per_ie), .step(step),
        .reload(load_val), .hit(per_hit)
    );

    rtc_ctl #(.DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctl_wr(wr_ctl), .wdata(bus_wdata),
        .tod_hit(tod_hit), .per_hit(per_hit), .run(run), .tod_ie(tod_ie),
        .per_ie(per_ie), .step(step), .ctl_rd(ctl_rd), .irq(irq)
    );

    // Read multiplexer keyed by byte offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_SECONDS))      bus_rdata = DATA_W'(sec);
        else if (bus_addr == ADDR_W'(OFS_FRACT))   bus_rdata = DATA_W'(sub);
        else if (bus_addr == ADDR_W'(OFS_TODALM))  bus_rdata = DATA_W'(tod_val);
        else if (bus_addr == ADDR_W'(OFS_PERLOAD)) bus_rdata = DATA_W'(load_val);
        else if (bus_addr == ADDR_W'(OFS_CONTROL)) bus_rdata = ctl_rd;
    end

    assert_tod_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tod_hit |=> ctl_rd[CB_TODF]);
    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctl_rd[CB_TODF] || ctl_rd[CB_PERF] || ctl_rd[CB_RDY]));
    assert_run_gates_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !run) |=> !step);
endmodule

// File: tb/test_rtc_core.sv
// Bench: drives the RTC core through its register bus and tick input and
// checks results against values computed from the requirements.
module test_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [4:0] A_SEC = 5'h00, A_SUB = 5'h04, A_TOD = 5'h08,
                           A_LOAD = 5'h0C, A_CTL = 5'h10;

    rtc_core i_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #2;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic tick_a();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk);
        #2;
        tick = 1'b0;
    endtask

    task automatic tick_once();
        tick_a();
        cyc(1);
    endtask

    logic [31:0] v;
    int exp_sub, exp_sec;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        rd(A_SEC, v);  chk("R1 sec", v, 0);
        rd(A_SUB, v);  chk("R1 sub", v, 0);
        rd(A_TOD, v);  chk("R1 tod", v, 0);
        rd(A_LOAD, v); chk("R1 load", v, 0);
        rd(A_CTL, v);  chk("R1 ctl", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R4: register map readback
        wr(A_SEC, 32'hDEAD_BEEF);  rd(A_SEC, v);  chk("R4 sec", v, 32'hDEAD_BEEF);
        wr(A_SUB, 32'h0000_01A5);  rd(A_SUB, v);  chk("R4 sub", v, 32'hA5);
        wr(A_TOD, 32'hFFFA_BCDE);  rd(A_TOD, v);  chk("R4 tod", v, 32'hABCDE);
        wr(A_LOAD, 32'h1234_5678); rd(A_LOAD, v); chk("R4 load", v, 32'h1234_5678);

        // R3: ticks ignored while stopped
        tick_once(); tick_once();
        rd(A_SUB, v); chk("R3 sub held", v, 32'hA5);
        rd(A_SEC, v); chk("R3 sec held", v, 32'hDEAD_BEEF);

        // R5: run write refused while unlock is 0
        wr(A_CTL, 32'h0000_0001);
        rd(A_CTL, v); chk("R5 busy after write", v[3], 1);
        cyc(5);
        rd(A_CTL, v); chk("R5 run locked", v[0], 0);

        // R6: busy window and deferred enable
        wr(A_CTL, 32'h0000_8000);
        cyc(5);
        wr(A_CTL, 32'h0000_8001);
        rd(A_CTL, v); chk("R6 busy set", v[3], 1); chk("R6 run old", v[0], 0);
        wr(A_CTL, 32'h0000_8000);
        cyc(2);
        rd(A_CTL, v); chk("R6 busy 4th cycle", v[3], 1); chk("R6 run still old", v[0], 0);
        cyc(1);
        rd(A_CTL, v); chk("R6 busy fell", v[3], 0); chk("R6 run new", v[0], 1);
        chk("R6 unlock kept", v[15], 1);

        // R2 and R7: count sweep with ready timing
        wr(A_SUB, 0);
        wr(A_SEC, 0);
        exp_sub = 0; exp_sec = 0;
        for (int i = 0; i < 600; i++) begin
            tick_a();
            rd(A_CTL, v); chk("R7 ready cleared at tick", v[4], 0);
            rd(A_SUB, v); chk("R2 sub before update", v, exp_sub);
            cyc(1);
            exp_sub = exp_sub + 1;
            if (exp_sub == 256) begin exp_sub = 0; exp_sec = exp_sec + 1; end
            rd(A_CTL, v); chk("R7 ready set at update", v[4], 1);
            rd(A_SUB, v); chk("R2 sub", v, exp_sub);
            rd(A_SEC, v); chk("R2 sec", v, exp_sec);
        end

        // R7: software clear, write 1 does not set; R11: flags not settable
        wr(A_CTL, 32'h0000_8001);
        rd(A_CTL, v); chk("R7 ready cleared by 0", v[4], 0);
        wr(A_CTL, 32'h0000_80D1);
        rd(A_CTL, v); chk("R7 ready not set by 1", v[4], 0);
        chk("R11 tod flag not set", v[6], 0);
        chk("R11 per flag not set", v[7], 0);
        cyc(5);

        // R8: time-of-day alarm
        wr(A_TOD, 5);
        wr(A_SEC, 4);
        wr(A_SUB, 32'hFE);
        tick_once();
        rd(A_CTL, v); chk("R8 no early hit", v[6], 0);
        tick_once();
        rd(A_SEC, v); chk("R8 sec reached", v, 5);
        rd(A_CTL, v); chk("R8 flag one edge later", v[6], 0);
        cyc(1);
        rd(A_CTL, v); chk("R8 flag set", v[6], 1);
        chk("R10 irq masked", {31'b0, irq}, 0);
        wr(A_CTL, 32'h0000_80C3);
        cyc(5);
        chk("R10 irq tod", {31'b0, irq}, 1);
        wr(A_CTL, 32'h0000_8083);
        rd(A_CTL, v); chk("R8 flag cleared", v[6], 0);
        chk("R10 irq dropped", {31'b0, irq}, 0);
        cyc(5);

        // R9: periodic alarm sweep over reload values
        for (int r = 0; r <= 5; r++) begin
            int per;
            per = (r == 0) ? 1 : r;
            wr(A_CTL, 32'h0000_8001);
            cyc(5);
            wr(A_LOAD, r);
            cyc(1);
            wr(A_CTL, 32'h0000_8005);
            cyc(5);
            for (int k = 1; k < per; k++) begin
                tick_once();
                rd(A_CTL, v); chk("R9 no early fire", v[7], 0);
            end
            tick_once();
            rd(A_CTL, v); chk("R9 fire", v[7], 1);
            chk("R10 irq periodic", {31'b0, irq}, 1);
            wr(A_CTL, 32'h0000_8005);
            rd(A_CTL, v); chk("R9 flag cleared", v[7], 0);
            cyc(5);
            for (int k = 1; k < per; k++) tick_once();
            tick_once();
            rd(A_CTL, v); chk("R9 second period", v[7], 1);
        end
        wr(A_CTL, 32'h0000_8001);
        cyc(5);
        rd(A_CTL, v); chk("R9 flag cleared at end", v[7], 0);

        // R10: ready interrupt
        wr(A_CTL, 32'h0000_8021);
        cyc(5);
        chk("R10 irq low before ready", {31'b0, irq}, 0);
        tick_once();
        chk("R10 irq from ready", {31'b0, irq}, 1);

        // R3 again: stop and confirm hold
        wr(A_CTL, 32'h0000_8000);
        cyc(5);
        rd(A_SUB, v); exp_sub = v;
        tick_once(); tick_once();
        rd(A_SUB, v); chk("R3 held after stop", v, exp_sub);

        // R5: relock, then run write refused
        wr(A_CTL, 32'h0000_0000);
        cyc(5);
        wr(A_CTL, 32'h0000_0001);
        cyc(5);
        rd(A_CTL, v); chk("R5 run refused after relock", v[0], 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule